// File: doc/BRIEF.md
# RNS Group Index Unit

This block takes a number held in residue form over the three moduli 2^N-1, 2^N and 2^N+1. It returns the group index of that number, which is the integer X the residues stand for with its N low bits removed. The block never rebuilds X. It forms two modular differences of the residues, which are the remainders of the group index modulo 2^N-1 and modulo 2^N+1. It then combines those two remainders into the index using only adders, a one-bit rotation and wiring.

A caller presents a residue triple with a valid strobe and receives the 2N-bit index one clock later. While the strobe is low the registered index holds its value. Overflow logic for residue adders is the intended consumer: it compares the group indices of two operands instead of comparing full-width integers.

The reset input is asserted asynchronously. Its release is synchronized to the clock through two flops, so the block leaves reset on the second rising edge after `rst_n` goes high.

Top module: `rnsg_group_idx`

## Requirements
- R1: While reset is asserted, and on the first edges after reset is released, `out_vld_o` is 0 and `grp_o` is 0.
- R2: `out_vld_o` is high in the cycle after a cycle with `in_vld` high, and low in the cycle after a cycle with `in_vld` low.
- R3: For every valid triple (`r1_i` = X mod (2^N-1) in 0..2^N-2, `r2_i` = X mod 2^N, `r3_i` = X mod (2^N+1) in 0..2^N), the output one cycle later equals floor(X / 2^N). Here X is any integer in 0..2^N(2^2N-1)-1.
- R4: Every valid output lies in 0..2^2N-2.
- R5: A valid output taken modulo 2^N-1 equals (`r1_i` - `r2_i`) mod (2^N-1) of the triple that produced it.
- R6: A valid output taken modulo 2^N+1 equals (`r2_i` - `r3_i`) mod (2^N+1) of the triple that produced it.
- R7: Some triples make the second-stage difference land on the single value -2^N. These are the triples with `r1_i` ≡ `r2_i` mod (2^N-1) and (`r2_i` - `r3_i`) mod (2^N+1) = 2^N. For them the output is still floor(X / 2^N).
- R8: While `in_vld` is low, `grp_o` keeps its previous value whatever the residue inputs do.
- R9: Let K = floor(G / (2^N+1)) and B = G mod (2^N+1). When K + B ≥ 2^N, the output is still floor(X / 2^N); this is the case where the low field carries into the high field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_vld | input | 1 | Residue triple valid; also the output register enable |
| r1_i | input | N | Residue modulo 2^N-1 |
| r2_i | input | N | Residue modulo 2^N |
| r3_i | input | N+1 | Residue modulo 2^N+1 |
| out_vld_o | output | 1 | Group index valid |
| grp_o | output | 2N | Group index floor(X / 2^N) |

## Verification
Two paths can fire in the same evaluation: the exception multiplexer that replaces an out-of-range difference, and the carry from the low-field sum into the high field. Every triple that triggers the exception also produces a carry, so both paths switch together for those inputs. The bench drives every X of the dynamic range into one instance at N=3 and one at N=4, which reaches all such triples. It judges each result against floor(X/2^N), computed from X itself, and against the two remainder identities. The checks are labelled so that exception cases and carry-only cases can be told apart.

// File: rtl/rnsg_pkg.sv
package rnsg_pkg;
  // Selects the modulus of a modular subtractor relative to 2^N.
  typedef enum logic {
    MOD_MINUS,   // 2^N - 1
    MOD_PLUS     // 2^N + 1
  } mod_kind_e;
endpackage

// File: rtl/rnsg_rst_sync.sv
module rnsg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/rnsg_modsub.sv
// Modular subtractor: (a - b) mod (2^N -/+ 1). When the raw difference is
// negative, the modulus is added back as an offset. The optional exception
// path catches the one raw value that a single offset cannot repair.
module rnsg_modsub
  import rnsg_pkg::*;
#(
  parameter int        N       = 4,
  parameter int        AW      = N,
  parameter int        BW      = N,
  parameter mod_kind_e KIND    = MOD_MINUS,
  parameter bit        HAS_EXC = 1'b0,
  localparam int       OW      = (KIND == MOD_PLUS) ? N + 1 : N
) (
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [OW-1:0] d_o
);
  localparam int RW = N + 2;
  localparam logic [RW-1:0] ONE_N = RW'(1) << N;
  localparam logic [RW-1:0] MODV  = (KIND == MOD_PLUS) ? ONE_N + RW'(1) : ONE_N - RW'(1);

  logic [RW-1:0] a_ext;
  logic [RW-1:0] b_ext;
  logic [RW-1:0] raw;
  logic [RW-1:0] fix;
  logic [OW-1:0] sum;

  always_comb begin
    a_ext = RW'(a_i);
    b_ext = RW'(b_i);
    raw   = a_ext - b_ext;
    fix   = raw[RW-1] ? MODV : '0;
    sum   = OW'(raw + fix);
  end

  generate
    if (HAS_EXC) begin : g_exc
      // Raw value -2^N maps to -2^N + 2*MOD after reduction.
      localparam logic [RW-1:0] EXC_IN  = ~ONE_N + RW'(1);
      localparam logic [RW-1:0] EXC_OUT = (MODV << 1) - ONE_N;
      logic hit;
      assign hit = (raw == EXC_IN);
      assign d_o = hit ? EXC_OUT[OW-1:0] : sum;
    end else begin : g_plain
      assign d_o = sum;
    end
  endgenerate
endmodule

// File: rtl/rnsg_rotr.sv
// One-bit right rotation: halves a value modulo 2^N-1.
module rnsg_rotr #(
  parameter int N = 4
) (
  input  logic [N-1:0] v_i,
  output logic [N-1:0] v_o
);
  assign v_o = {v_i[0], v_i[N-1:1]};
endmodule

// File: rtl/rnsg_merge.sv
// G = K*(2^N+1) + B = K*2^N + (K + B). K*2^N is wiring; the low-field
// sum K+B may carry one into the high field.
module rnsg_merge #(
  parameter int N = 4
) (
  input  logic [N-1:0]   k_i,
  input  logic [N:0]     b_i,
  output logic [2*N-1:0] grp_o
);
  logic [N:0]   low_sum;
  logic [N-1:0] high;

  always_comb begin
    low_sum = {1'b0, k_i} + b_i;
    high    = k_i + N'(low_sum[N]);
    grp_o   = {high, low_sum[N-1:0]};
  end
endmodule

// File: rtl/rnsg_group_idx.sv
module rnsg_group_idx
  import rnsg_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [N-1:0]   r1_i,
  input  logic [N-1:0]   r2_i,
  input  logic [N:0]     r3_i,
  output logic           out_vld_o,
  output logic [2*N-1:0] grp_o
);
  localparam int GW = 2 * N;

  logic          rst_q_n;
  logic [N-1:0]  rem_lo;    // G mod (2^N-1)
  logic [N:0]    rem_hi;    // G mod (2^N+1)
  logic [N-1:0]  diff_raw;  // (rem_lo - rem_hi) mod (2^N-1)
  logic [N-1:0]  k_mult;    // diff_raw / 2 mod (2^N-1)
  logic [GW-1:0] grp_nxt;

  logic [GW-1:0] grp_d, grp_q;
  logic          vld_d, vld_q;

  rnsg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  rnsg_modsub #(.N(N), .AW(N), .BW(N), .KIND(MOD_MINUS), .HAS_EXC(1'b0)) u_sub_lo (
    .a_i (r1_i),
    .b_i (r2_i),
    .d_o (rem_lo)
  );

  rnsg_modsub #(.N(N), .AW(N), .BW(N+1), .KIND(MOD_PLUS), .HAS_EXC(1'b0)) u_sub_hi (
    .a_i (r2_i),
    .b_i (r3_i),
    .d_o (rem_hi)
  );

  rnsg_modsub #(.N(N), .AW(N), .BW(N+1), .KIND(MOD_MINUS), .HAS_EXC(1'b1)) u_sub_mix (
    .a_i (rem_lo),
    .b_i (rem_hi),
    .d_o (diff_raw)
  );

  rnsg_rotr #(.N(N)) u_rot (
    .v_i (diff_raw),
    .v_o (k_mult)
  );

  rnsg_merge #(.N(N)) u_merge (
    .k_i   (k_mult),
    .b_i   (rem_hi),
    .grp_o (grp_nxt)
  );

  always_comb begin
    vld_d = in_vld;
    grp_d = in_vld ? grp_nxt : grp_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q <= 1'b0;
      grp_q <= '0;
    end else begin
      vld_q <= vld_d;
      grp_q <= grp_d;
    end
  end

  assign out_vld_o = vld_q;
  assign grp_o     = grp_q;
endmodule

// File: rtl/rnsg_group_idx_chk.sv
module rnsg_group_idx_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst_sn,
  input logic           in_vld,
  input logic [N-1:0]   r1_i,
  input logic [N-1:0]   r2_i,
  input logic [N:0]     r3_i,
  input logic           out_vld_o,
  input logic [2*N-1:0] grp_o
);
  localparam int M1   = (1 << N) - 1;
  localparam int M3   = (1 << N) + 1;
  localparam int GMAX = (1 << (2 * N)) - 2;

  function automatic int md(input int v, input int m);
    return ((v % m) + m) % m;
  endfunction

  assert_vld_follow_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    in_vld |=> out_vld_o);
  assert_vld_idle_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    !in_vld |=> !out_vld_o);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    !in_vld |=> $stable(grp_o));
  assert_range_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    out_vld_o |-> (int'(grp_o) <= GMAX));
  assert_rem_lo_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    in_vld |=> md(int'(grp_o), M1) == md(int'($past(r1_i)) - int'($past(r2_i)), M1));
  assert_rem_hi_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    in_vld |=> md(int'(grp_o), M3) == md(int'($past(r2_i)) - int'($past(r3_i)), M3));
endmodule

bind rnsg_group_idx rnsg_group_idx_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_q_n),
  .in_vld    (in_vld),
  .r1_i      (r1_i),
  .r2_i      (r2_i),
  .r3_i      (r3_i),
  .out_vld_o (out_vld_o),
  .grp_o     (grp_o)
);

// File: tb/rnsg_group_idx_tb_top.sv
module rnsg_group_idx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 3;
  localparam int NB = 4;
  localparam int RANGE_A = (1 << NA) * ((1 << (2 * NA)) - 1);
  localparam int RANGE_B = (1 << NB) * ((1 << (2 * NB)) - 1);

  typedef struct {
    int    g;
    int    d1;
    int    d3;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic            vld_a, vld_b;
  logic [NA-1:0]   r1_a, r2_a;
  logic [NA:0]     r3_a;
  logic [NB-1:0]   r1_b, r2_b;
  logic [NB:0]     r3_b;
  logic            ov_a, ov_b;
  logic [2*NA-1:0] grp_a;
  logic [2*NB-1:0] grp_b;

  rnsg_group_idx #(.N(NA)) dut3_i (
    .clk(clk), .rst_n(rst_n), .in_vld(vld_a), .r1_i(r1_a), .r2_i(r2_a),
    .r3_i(r3_a), .out_vld_o(ov_a), .grp_o(grp_a));

  rnsg_group_idx #(.N(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(vld_b), .r1_i(r1_b), .r2_i(r2_b),
    .r3_i(r3_b), .out_vld_o(ov_b), .grp_o(grp_b));

  item_t qa[$];
  item_t qb[$];
  int    checks = 0;
  int    errors = 0;
  int    last_a = 0;
  int    last_b = 0;
  bit    mon_en = 1'b0;
  bit    finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int md(input int v, input int m);
    return ((v % m) + m) % m;
  endfunction

  // Expected item built from X alone.
  function automatic item_t mk(input int x, input int n);
    item_t it;
    int m1, m2, m3, r1, r2, r3, k, b;
    m1 = (1 << n) - 1; m2 = 1 << n; m3 = (1 << n) + 1;
    r1 = x % m1; r2 = x % m2; r3 = x % m3;
    it.g  = x / m2;
    it.d1 = md(r1 - r2, m1);
    it.d3 = md(r2 - r3, m3);
    k = it.g / m3;
    b = it.g % m3;
    if (it.d1 == 0 && it.d3 == m2) it.tag = "R7 exception index";
    else if (k + b >= m2)          it.tag = "R9 carry index";
    else                           it.tag = "R3 index";
    return it;
  endfunction

  task automatic drive(input int x);
    if (x < RANGE_A) begin
      vld_a = 1'b1;
      r1_a = NA'(x % ((1 << NA) - 1));
      r2_a = NA'(x % (1 << NA));
      r3_a = (NA+1)'(x % ((1 << NA) + 1));
      qa.push_back(mk(x, NA));
    end else begin
      vld_a = 1'b0;
      r1_a = NA'(x); r2_a = NA'(x >> 1); r3_a = (NA+1)'(x >> 2);
    end
    vld_b = 1'b1;
    r1_b = NB'(x % ((1 << NB) - 1));
    r2_b = NB'(x % (1 << NB));
    r3_b = (NB+1)'(x % ((1 << NB) + 1));
    qb.push_back(mk(x, NB));
  endtask

  task automatic mon(input logic ov, input int g, input int n,
                     ref item_t q[$], ref int last);
    item_t it;
    if (ov) begin
      chk(q.size() == 1, "R2 result one cycle after strobe", q.size(), 1);
      if (q.size() > 0) begin
        it = q.pop_front();
        chk(g == it.g, it.tag, g, it.g);
        chk(g <= (1 << (2 * n)) - 2, "R4 range", g, (1 << (2 * n)) - 2);
        chk(md(g, (1 << n) - 1) == it.d1, "R5 remainder low", md(g, (1 << n) - 1), it.d1);
        chk(md(g, (1 << n) + 1) == it.d3, "R6 remainder high", md(g, (1 << n) + 1), it.d3);
        last = g;
      end
    end else begin
      chk(q.size() == 0, "R2 no result without strobe", q.size(), 0);
      chk(g == last, "R8 hold", g, last);
    end
  endtask

  // Monitor: a quarter period after each rising edge.
  always begin
    @(posedge clk);
    #(CLK_PERIOD / 4);
    if (mon_en) begin
      mon(ov_a, int'(grp_a), NA, qa, last_a);
      mon(ov_b, int'(grp_b), NB, qb, last_b);
    end
  end

  initial begin
    rst_n = 1'b0;
    vld_a = 1'b0; r1_a = '0; r2_a = '0; r3_a = '0;
    vld_b = 1'b0; r1_b = '0; r2_b = '0; r3_b = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD / 4);
    chk(ov_a == 1'b0 && ov_b == 1'b0, "R1 valid in reset", int'(ov_a | ov_b), 0);
    chk(grp_a == '0 && grp_b == '0, "R1 index in reset", int'(grp_b), 0);
    @(negedge clk);
    vld_a = 1'b1; vld_b = 1'b1;
    r1_b = 4'd5; r2_b = 4'd3; r3_b = 5'd9;
    rst_n = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD / 4);
    chk(ov_b == 1'b0 && grp_b == '0, "R1 first edge after release", int'(grp_b), 0);
    @(negedge clk);
    vld_a = 1'b0; vld_b = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD / 4);
    chk(ov_a == 1'b0 && ov_b == 1'b0, "R1 valid after release", int'(ov_a | ov_b), 0);
    chk(grp_a == '0 && grp_b == '0, "R1 index after release", int'(grp_b), 0);
    @(negedge clk);
    mon_en = 1'b1;
    for (int x = 0; x < RANGE_B; x++) begin
      drive(x);
      @(negedge clk);
    end
    vld_a = 1'b0; vld_b = 1'b0;
    for (int i = 0; i < 6; i++) begin
      r1_a = NA'(i); r2_a = NA'(i + 3); r3_a = (NA+1)'(i * 5);
      r1_b = NB'(i * 7); r2_b = NB'(i + 1); r3_b = (NB+1)'(i * 3);
      @(negedge clk);
    end
    repeat (2) @(posedge clk);
    #(CLK_PERIOD / 4);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule